// File: doc/BRIEF.md
# Synchronous Grouped Clock-Output Gate

The block takes one free-running reference clock and produces six gated copies of it. The copies are split into two groups, and each group has its own enable input. The wide group covers outputs 0 to 4 and is controlled by `en_a`. The narrow group is output 5 alone and is controlled by `en_b`. A disabled output is held at logic low. An enabled output follows the reference clock with the same phase.

The enables may change at any time, with no relation to the clock. Each enable goes through a chain of flops clocked by the reference clock. The last value in that chain is then registered on the falling clock edge. A group's gate can therefore switch only while the clock is low, so a group starting or stopping always shows whole pulses. An enable sampled at a rising edge takes effect at the output exactly four rising edges later. An active-low asynchronous reset clears both chains and parks every output low.

Top module: `grouped_clk_gate`

## Requirements
- R1: While its group is enabled, an output is high whenever the reference clock is high and low whenever the reference clock is low.
- R2: Outputs 0 to 4 follow `en_a` as one group, and output 5 follows `en_b` alone.
- R3: While `rst_n` is low, every output stays low whatever the enables are. After reset is released, every output stays low until an enable has passed through the full delay chain.
- R4: A disabled output is low during both halves of every reference period.
- R5: The four enable combinations give these results: 00 means all outputs low, `en_a` only means outputs 0-4 toggle, `en_b` only means output 5 toggles, and both high means all six toggle.
- R6: If an enable is first sampled high at rising edge n, the first output pulse of its group begins at rising edge n+4 and not at edge n+3.
- R7: If an enable is first sampled low at rising edge n, the last output pulse of its group begins at rising edge n+3, and the group is low from edge n+4 on.
- R8: Every output high pulse lasts exactly one half reference period, so no pulse is shortened when a group starts or stops.
- R9: An enable that is high for exactly one sampled rising edge produces exactly one full output pulse in its group.
- R10: Changing one group's enable has no effect on the other group's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_a | input | 1 | Asynchronous enable for outputs 0 to 4 |
| en_b | input | 1 | Asynchronous enable for output 5 |
| clk_out | output | 6 | Gated clock copies; bit 5 belongs to the narrow group |

## Verification
The enables are driven through all four combinations, held for several cycles each. This shows whether the group mapping is correct and whether a disabled output is parked low rather than left toggling. Each change of enable is scored in its exact due cycle, with the previous level expected up to one cycle before. An early-by-one or late-by-one pipeline is therefore caught, and so is a wrong start or stop cycle. A one-cycle enable pulse tests whether a single sampled value comes through as exactly one whole pulse. Measuring the width of every high pulse on outputs 0 and 5 shows any gate that switches while the clock is high.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;
  localparam int unsigned NUM_GROUPS = 2;

  // Group index served by output idx: the first a_cnt outputs form group 0.
  function automatic int unsigned group_sel(input int unsigned idx, input int unsigned a_cnt);
    return (idx < a_cnt) ? 0 : 1;
  endfunction
endpackage

// File: rtl/en_sync_pipe.sv
`timescale 1ns/1ps
module en_sync_pipe #(
  parameter int unsigned STAGES = 4   // must be at least 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic en_async,
  output logic en_late
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], en_async};
  end

  assign en_late = stg[STAGES-1];

  genvar k;
  generate
    for (k = 1; k < STAGES; k++) begin : g_shift_chk
      AST_PIPE_SHIFT: assert property (@(posedge ref_clk) disable iff (!rst_n)
        stg[k] == $past(stg[k-1])); // R6
    end
  endgenerate

  AST_PIPE_RESET_CLEAR: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(rst_n) |-> (stg == '0)); // R3
endmodule

// File: rtl/neg_gate.sv
`timescale 1ns/1ps
module neg_gate (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic en_in,
  output logic gate_q
);
  // Captured on the falling edge: the gate moves only while the clock is low.
  always_ff @(negedge ref_clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= en_in;
  end

  // The value seen at a rising edge was taken half a cycle earlier from the chain tail.
  AST_GATE_HALF_CYCLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    gate_q == en_in); // R8
endmodule

// File: rtl/grouped_clk_gate.sv
`timescale 1ns/1ps
module grouped_clk_gate #(
  parameter int unsigned NUM_OUT     = 6,
  parameter int unsigned GROUP_A_CNT = 5,
  parameter int unsigned LATENCY     = 4   // rising edges from sampling to effect, >= 2
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic               en_a,
  input  logic               en_b,
  output logic [NUM_OUT-1:0] clk_out
);
  import clkgate_pkg::*;

  localparam int unsigned PIPE_STAGES = LATENCY;

  logic [NUM_GROUPS-1:0] en_raw;
  logic [NUM_GROUPS-1:0] en_late;
  logic [NUM_GROUPS-1:0] grp_gate;

  assign en_raw = {en_b, en_a};

  genvar g, i;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
      en_sync_pipe #(.STAGES(PIPE_STAGES)) i_pipe (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .en_async(en_raw[g]),
        .en_late (en_late[g])
      );
      neg_gate i_gate (
        .ref_clk(ref_clk),
        .rst_n  (rst_n),
        .en_in  (en_late[g]),
        .gate_q (grp_gate[g])
      );
    end
    for (i = 0; i < NUM_OUT; i++) begin : g_out
      assign clk_out[i] = ref_clk & grp_gate[group_sel(i, GROUP_A_CNT)];
    end
  endgenerate

  // Wide group outputs all show the same level during the high phase.
  AST_GROUP_COHERENT: assert property (@(negedge ref_clk) disable iff (!rst_n)
    ($countones(clk_out[GROUP_A_CNT-1:0]) == 0) ||
    ($countones(clk_out[GROUP_A_CNT-1:0]) == GROUP_A_CNT)); // R2

  // Outputs are parked low in the low phase of the reference clock.
  AST_LOW_PHASE_PARKED: assert property (@(posedge ref_clk) disable iff (!rst_n)
    clk_out == '0); // R4
endmodule

// File: tb/test_grouped_clk_gate.sv
`timescale 1ns/1ps
module test_grouped_clk_gate;
  localparam int NOUT = 6;
  localparam int NA   = 5;
  localparam int LAT  = 4;

  logic            ref_clk = 1'b0;
  logic            rst_n   = 1'b0;
  logic            en_a    = 1'b0;
  logic            en_b    = 1'b0;
  logic [NOUT-1:0] clk_out;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    int    due;
    logic  a;
    logic  b;
    string req;
  } exp_t;
  exp_t q[$];
  exp_t e;
  logic [NOUT-1:0] expv;

  grouped_clk_gate #(.NUM_OUT(NOUT), .GROUP_A_CNT(NA), .LATENCY(LAT)) i_grouped_clk_gate (
    .ref_clk(ref_clk),
    .rst_n  (rst_n),
    .en_a   (en_a),
    .en_b   (en_b),
    .clk_out(clk_out)
  );

  always #5 ref_clk = ~ref_clk;

  task automatic check(input bit ok, input string req, input logic [NOUT-1:0] act,
                       input logic [NOUT-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: clk_out=%b expected %b", req, cyc, act, exp);
    end
  endtask

  // Driver: set inputs in the low phase and push the expected group levels.
  task automatic step(input logic a, input logic b, input string req);
    @(negedge ref_clk);
    en_a = a;
    en_b = b;
    q.push_back('{cyc + 1 + LAT, a, b, req});
  endtask

  task automatic hold(input logic a, input logic b, input int n, input string first_req,
                      input string rest_req);
    for (int k = 0; k < n; k++) step(a, b, (k == 0) ? first_req : rest_req);
  endtask

  // Monitor: score the high phase and then the low phase of every due cycle.
  always @(posedge ref_clk) begin
    cyc = cyc + 1;
    #2;
    while (q.size() > 0 && q[0].due < cyc) begin
      e = q.pop_front();
      check(1'b0, e.req, clk_out, 'x);
    end
    if (q.size() > 0 && q[0].due == cyc) begin
      e = q.pop_front();
      expv = {e.b, {NA{e.a}}};
      check(clk_out === expv, e.req, clk_out, expv);          // R1 R2 R5 R6 R7
      #5;
      check(clk_out === '0, "R4", clk_out, '0);
    end
  end

  // Pulse-width monitors on one output of each group (R8).
  realtime t_rise0, t_rise5;
  always @(posedge clk_out[0]) t_rise0 = $realtime;
  always @(posedge clk_out[5]) t_rise5 = $realtime;
  always @(negedge clk_out[0]) begin
    checks++;
    if ($realtime - t_rise0 != 5.0) begin
      errors++;
      $display("FAIL R8 output 0 pulse width %0t expected 5ns", $realtime - t_rise0);
    end
  end
  always @(negedge clk_out[5]) begin
    checks++;
    if ($realtime - t_rise5 != 5.0) begin
      errors++;
      $display("FAIL R8 output 5 pulse width %0t expected 5ns", $realtime - t_rise5);
    end
  end

  // Count pulses on output 5 for the single-cycle enable case (R9).
  int pulses5 = 0;
  always @(posedge clk_out[5]) pulses5++;

  initial begin
    // R3: enables high while reset held, outputs must stay low.
    en_a = 1'b1;
    en_b = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge ref_clk);
      #2 check(clk_out === '0, "R3", clk_out, '0);
    end
    @(negedge ref_clk);
    rst_n = 1'b1;
    en_a  = 1'b0;
    en_b  = 1'b0;

    hold(1'b0, 1'b0, 6, "R3", "R5");
    hold(1'b1, 1'b0, 8, "R6", "R5");
    hold(1'b1, 1'b1, 8, "R10", "R5");
    hold(1'b0, 1'b1, 8, "R7", "R10");
    hold(1'b0, 1'b0, 6, "R7", "R4");

    // R9: one-cycle pulse on en_b gives one output pulse on bit 5.
    pulses5 = 0;
    step(1'b0, 1'b1, "R9");
    hold(1'b0, 1'b0, 7, "R9", "R9");
    checks++;
    if (pulses5 != 1) begin
      errors++;
      $display("FAIL R9 output 5 pulse count %0d expected 1", pulses5);
    end

    hold(1'b1, 1'b1, 6, "R6", "R1");
    hold(1'b1, 1'b0, 6, "R10", "R2");
    repeat (LAT + 3) @(posedge ref_clk);
    #3;
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R6 %0d expectations left expected 0", q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog expired, run incomplete expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule